// File: doc/BRIEF.md
# Pointer lower-bound check unit

This execution-stage block checks one pointer against the lower limit held in a selected bound register. For each accepted request it decides among three outcomes. The operation completes normally, or it raises a bound-range fault, or it raises an invalid-opcode fault. The caller supplies the pointer, which is either a register operand or an effective address that has already been computed. Address generation, upper-limit checks and exception delivery belong to other parts of the pipeline.

Before the comparator's answer counts, a set of legality rules is applied. These depend on the processor mode and cover the lock prefix, the effective addressing size and the bound-register index. An illegal encoding always yields an invalid-opcode result. Only a real bound violation writes the bound status register.

Top module: `ptrLowBoundChk`

## Requirements
- R1: The pointer is compared with the lower bound as an unsigned number, and a bound fault is reported only when the pointer is strictly smaller than the bound.
- R2: A pointer equal to the lower bound passes.
- R3: The status write strobe `statusWe` is high exactly in the cycles where `resBoundFault` is high, and it carries `statusData` = 0x01. In every other cycle `statusWe` is low and `statusData` is 0.
- R4: In 64-bit mode the full 64-bit operand is compared. In every other mode only bits 31:0 of the operand are used, zero-extended to 64 bits before the comparison.
- R5: When `lockPrefix` is set, the result is invalid-opcode in every mode.
- R6: A `bndIdx` of 4 or above (4 to 15) gives invalid-opcode in every mode. Only indices 0 to 3 are legal.
- R7: In protected mode (`cpuMode`=2) and compatibility mode (`cpuMode`=3), the effective addressing is 16-bit when `addrOverride` equals `csDefault32`, and this gives invalid-opcode. The two cases are override 0 with default-size 0, and override 1 with default-size 1.
- R8: The same 16-bit rule applies in real mode (`cpuMode`=0) and virtual-8086 mode (`cpuMode`=1). In 64-bit mode (`cpuMode`=4) no addressing-size fault is raised.
- R9: Invalid-opcode takes priority over the comparison. When it is reported, no bound fault is reported and the status register is not written.
- R10: Each cycle with `inValid` high produces, one clock later, one cycle of `resValid` with exactly one of `resPass`, `resBoundFault` or `resBadOpcode` high. When `resValid` is low, all three are low.
- R11: `memForm` has no effect on the result. The effective address is checked exactly like a register operand.
- R12: The unused mode codes 5, 6 and 7 give invalid-opcode.
- R13: While reset is held, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| cpuMode | input | 3 | 0 real, 1 virtual-8086, 2 protected, 3 compatibility, 4 64-bit, 5-7 unused |
| csDefault32 | input | 1 | Code-segment default-size bit |
| addrOverride | input | 1 | Address-size override prefix present |
| lockPrefix | input | 1 | Lock prefix present |
| bndIdx | input | IDX_W (4) | Bound-register index |
| memForm | input | 1 | 1: operand is an effective address; 0: register operand |
| operand | input | ADDR_W (64) | Pointer to check |
| lowerBound | input | ADDR_W (64) | Lower bound of the selected register |
| resValid | output | 1 | Result valid |
| resPass | output | 1 | Check passed |
| resBoundFault | output | 1 | Bound-range fault |
| resBadOpcode | output | 1 | Invalid-opcode fault |
| statusWe | output | 1 | Bound status register write enable |
| statusData | output | 8 | Value to write to the status register |

## Verification
The bench uses the default parameters: a 64-bit full width, a 32-bit narrow width, a 4-bit index and four legal bound registers. With a 4-bit index, illegal indices 4 through 15 can be driven in every mode. The 64/32 split lets directed vectors set the upper operand bits so that the outcome differs between the 64-bit comparison and the zero-extended narrow one. Random traffic mixes every mode code, both prefixes, the default-size bit and operands placed near the bound, and a behavioural model is compared against the outputs on every clock.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  localparam int STATUS_W = 8;
  localparam logic [STATUS_W-1:0] BR_STATUS = 8'h01;

  typedef enum logic [2:0] {
    MODE_REAL   = 3'd0,
    MODE_V86    = 3'd1,
    MODE_PROT   = 3'd2,
    MODE_COMPAT = 3'd3,
    MODE_LONG   = 3'd4
  } cpuMode_e;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic accept;     // request present this cycle
    logic badOpcode;  // encoding illegal in the current mode
    logic wideCmp;    // compare full width (64-bit mode)
  } lbcStrobe_t;

endpackage

// File: rtl/lbcControl.sv
module lbcControl
  import lbc_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int NUM_BND = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [2:0]       cpuMode,
  input  logic             csDefault32,
  input  logic             addrOverride,
  input  logic             lockPrefix,
  input  logic [IDX_W-1:0] bndIdx,
  input  logic             belowBound,
  output lbcStrobe_t       strobe,
  output logic             resValid,
  output logic             resPass,
  output logic             resBoundFault,
  output logic             resBadOpcode
);

  localparam logic [IDX_W:0] BND_LIMIT = (IDX_W+1)'(NUM_BND);

  logic isLong;
  logic knownMode;
  logic idxBad;
  logic addr16;
  logic badOp;

  always_comb begin
    isLong    = (cpuMode == 3'(MODE_LONG));
    knownMode = (cpuMode <= 3'(MODE_LONG));
    idxBad    = ({1'b0, bndIdx} >= BND_LIMIT);
    // effective addressing is 16-bit when the override flips a 32-bit default
    // or leaves a 16-bit default in place; not applicable in 64-bit mode
    addr16    = !isLong && (addrOverride == csDefault32);
    badOp     = lockPrefix || !knownMode || idxBad || addr16;

    strobe.accept    = inValid;
    strobe.badOpcode = badOp;
    strobe.wideCmp   = isLong;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid      <= 1'b0;
      resPass       <= 1'b0;
      resBoundFault <= 1'b0;
      resBadOpcode  <= 1'b0;
    end else begin
      resValid      <= inValid;
      resBadOpcode  <= inValid && badOp;
      resBoundFault <= inValid && !badOp && belowBound;
      resPass       <= inValid && !badOp && !belowBound;
    end
  end

  AST_LOCK_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && lockPrefix) |=> (resBadOpcode && !resPass && !resBoundFault)); // R5

  AST_IDX_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ({1'b0, bndIdx} >= BND_LIMIT)) |=> resBadOpcode); // R6

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ($countones({resPass, resBoundFault, resBadOpcode}) == 1)); // R10

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> !(resPass || resBoundFault || resBadOpcode)); // R10

  AST_LATENCY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> resValid); // R10

endmodule

// File: rtl/lbcDatapath.sv
module lbcDatapath
  import lbc_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  lbcStrobe_t          strobe,
  input  logic                memForm,
  input  logic [ADDR_W-1:0]   operand,
  input  logic [ADDR_W-1:0]   lowerBound,
  output logic                belowBound,
  output logic                statusWe,
  output logic [STATUS_W-1:0] statusData
);

  localparam int PAD_W = ADDR_W - NARROW_W;

  logic [ADDR_W-1:0] narrowVal;
  logic [ADDR_W-1:0] cmpVal;
  logic              brHit;

  generate
    if (PAD_W > 0) begin : g_extend
      assign narrowVal = {{PAD_W{1'b0}}, operand[NARROW_W-1:0]};
    end else begin : g_same
      assign narrowVal = operand;
    end
  endgenerate

  always_comb begin
    cmpVal     = strobe.wideCmp ? operand : narrowVal;
    belowBound = (cmpVal < lowerBound);
    brHit      = strobe.accept && !strobe.badOpcode && belowBound;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusWe   <= 1'b0;
      statusData <= '0;
    end else begin
      statusWe   <= brHit;
      statusData <= brHit ? BR_STATUS : '0;
    end
  end

  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rstN)
    statusWe |-> (statusData == BR_STATUS)); // R3

  AST_BAD_NO_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && strobe.badOpcode) |=> !statusWe); // R9

  AST_MEM_FORM_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accept && memForm && !strobe.badOpcode && strobe.wideCmp &&
     (operand < lowerBound)) |=> statusWe); // R11

endmodule

// File: rtl/ptrLowBoundChk.sv
module ptrLowBoundChk
  import lbc_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 32,
  parameter int IDX_W    = 4,
  parameter int NUM_BND  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [2:0]          cpuMode,
  input  logic                csDefault32,
  input  logic                addrOverride,
  input  logic                lockPrefix,
  input  logic [IDX_W-1:0]    bndIdx,
  input  logic                memForm,
  input  logic [ADDR_W-1:0]   operand,
  input  logic [ADDR_W-1:0]   lowerBound,
  output logic                resValid,
  output logic                resPass,
  output logic                resBoundFault,
  output logic                resBadOpcode,
  output logic                statusWe,
  output logic [STATUS_W-1:0] statusData
);

  lbcStrobe_t ctlStrobe;
  logic       belowBound;

  lbcControl #(
    .IDX_W  (IDX_W),
    .NUM_BND(NUM_BND)
  ) i_control (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .cpuMode      (cpuMode),
    .csDefault32  (csDefault32),
    .addrOverride (addrOverride),
    .lockPrefix   (lockPrefix),
    .bndIdx       (bndIdx),
    .belowBound   (belowBound),
    .strobe       (ctlStrobe),
    .resValid     (resValid),
    .resPass      (resPass),
    .resBoundFault(resBoundFault),
    .resBadOpcode (resBadOpcode)
  );

  lbcDatapath #(
    .ADDR_W  (ADDR_W),
    .NARROW_W(NARROW_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (ctlStrobe),
    .memForm   (memForm),
    .operand   (operand),
    .lowerBound(lowerBound),
    .belowBound(belowBound),
    .statusWe  (statusWe),
    .statusData(statusData)
  );

  AST_STATUS_TRACKS_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    statusWe == resBoundFault); // R3

endmodule

// File: tb/test_ptrLowBoundChk.sv
module test_ptrLowBoundChk;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  cpuMode = 3'd0;
  logic        csDefault32 = 1'b0;
  logic        addrOverride = 1'b0;
  logic        lockPrefix = 1'b0;
  logic [3:0]  bndIdx = 4'd0;
  logic        memForm = 1'b0;
  logic [63:0] operand = '0;
  logic [63:0] lowerBound = '0;
  logic        resValid, resPass, resBoundFault, resBadOpcode, statusWe;
  logic [7:0]  statusData;

  int nChecks = 0;
  int nErr = 0;
  int expQ[$];      // 0 idle, 1 pass, 2 bound fault, 3 invalid opcode
  string tagQ[$];

  always #5 clk = ~clk;

  ptrLowBoundChk i_ptrLowBoundChk (
    .clk(clk), .rstN(rstN), .inValid(inValid), .cpuMode(cpuMode),
    .csDefault32(csDefault32), .addrOverride(addrOverride),
    .lockPrefix(lockPrefix), .bndIdx(bndIdx), .memForm(memForm),
    .operand(operand), .lowerBound(lowerBound), .resValid(resValid),
    .resPass(resPass), .resBoundFault(resBoundFault),
    .resBadOpcode(resBadOpcode), .statusWe(statusWe), .statusData(statusData)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int refKind(input logic v, input logic [2:0] m,
      input logic d, input logic ovr, input logic lock, input logic [3:0] idx,
      input logic [63:0] op, input logic [63:0] lb);
    logic [63:0] val;
    if (!v) return 0;
    if (lock || m > 3'd4 || idx >= 4'd4) return 3;
    if (m != 3'd4 && ovr == d) return 3;
    val = (m == 3'd4) ? op : {32'h0, op[31:0]};
    return (val < lb) ? 2 : 1;
  endfunction

  function automatic string refTag(input logic [2:0] m, input logic d,
      input logic ovr, input logic lock, input logic [3:0] idx,
      input logic mem, input logic [63:0] op, input logic [63:0] lb);
    logic [63:0] val;
    if (lock) return "R5";
    if (m > 3'd4) return "R12";
    if (idx >= 4'd4) return "R6";
    if (m != 3'd4 && ovr == d) return (m <= 3'd1) ? "R8" : "R7";
    val = (m == 3'd4) ? op : {32'h0, op[31:0]};
    if (val == lb) return "R2";
    if (m != 3'd4 && op[63:32] != 0) return "R4";
    if (mem) return "R11";
    return "R1";
  endfunction

  task automatic compareOut();
    int e;
    string t;
    if (expQ.size() == 0) return;
    e = expQ.pop_front();
    t = tagQ.pop_front();
    check(resValid == (e != 0), "R10 valid", 64'(resValid), 64'(e != 0));
    check($countones({resPass, resBoundFault, resBadOpcode}) == ((e != 0) ? 1 : 0),
          "R10 onehot", 64'({resPass, resBoundFault, resBadOpcode}), 64'(e != 0));
    check(resPass == (e == 1), t, 64'(resPass), 64'(e == 1));
    check(resBoundFault == (e == 2), t, 64'(resBoundFault), 64'(e == 2));
    check(resBadOpcode == (e == 3), (e == 3) ? "R9" : t, 64'(resBadOpcode), 64'(e == 3));
    check(statusWe == (e == 2), (e == 3) ? "R9" : "R3", 64'(statusWe), 64'(e == 2));
    check(statusData == ((e == 2) ? 8'h01 : 8'h00), "R3", 64'(statusData),
          64'((e == 2) ? 8'h01 : 8'h00));
  endtask

  task automatic step(input logic v, input logic [2:0] m, input logic d,
      input logic ovr, input logic lock, input logic [3:0] idx, input logic mem,
      input logic [63:0] op, input logic [63:0] lb);
    @(negedge clk);
    compareOut();
    inValid = v; cpuMode = m; csDefault32 = d; addrOverride = ovr;
    lockPrefix = lock; bndIdx = idx; memForm = mem; operand = op; lowerBound = lb;
    expQ.push_back(refKind(v, m, d, ovr, lock, idx, op, lb));
    tagQ.push_back(v ? refTag(m, d, ovr, lock, idx, mem, op, lb) : "R10");
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    nErr++;
    nChecks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finishRun();
  end

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    check({resValid, resPass, resBoundFault, resBadOpcode, statusWe} == 5'b0 &&
          statusData == 8'h00, "R13",
          64'({resValid, resPass, resBoundFault, resBadOpcode, statusWe}), 64'h0);
    rstN = 1'b1;

    // comparator, 64-bit mode
    step(1, 3'd4, 0, 0, 0, 4'd0, 0, 64'd100, 64'd100);
    step(1, 3'd4, 0, 0, 0, 4'd1, 0, 64'd99, 64'd100);
    step(1, 3'd4, 0, 0, 0, 4'd2, 0, 64'h8000_0000_0000_0000, 64'd1);
    step(1, 3'd4, 1, 1, 0, 4'd3, 0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    // narrow zero-extension
    step(1, 3'd2, 1, 0, 0, 4'd0, 0, 64'hFFFF_FFFF_0000_0010, 64'h20);
    step(1, 3'd4, 1, 0, 0, 4'd0, 0, 64'hFFFF_FFFF_0000_0010, 64'h20);
    step(1, 3'd3, 1, 0, 0, 4'd0, 0, 64'hFFFF_FFFF, 64'h1_0000_0000);
    step(1, 3'd0, 0, 1, 0, 4'd0, 0, 64'h1234_0000_0000_0040, 64'h40);
    // lock prefix in each mode
    for (int m = 0; m < 5; m++)
      step(1, 3'(m), 1, 0, 1, 4'd0, 0, 64'd5, 64'd9);
    // bound-register index
    step(1, 3'd4, 0, 0, 0, 4'd4, 0, 64'd1, 64'd9);
    step(1, 3'd4, 0, 0, 0, 4'd15, 0, 64'd1, 64'd9);
    step(1, 3'd2, 1, 0, 0, 4'd5, 0, 64'd1, 64'd9);
    step(1, 3'd1, 0, 1, 0, 4'd7, 0, 64'd1, 64'd9);
    step(1, 3'd3, 1, 0, 0, 4'd3, 0, 64'd9, 64'd9);
    // addressing size
    step(1, 3'd2, 0, 0, 0, 4'd0, 0, 64'd1, 64'd9);
    step(1, 3'd3, 1, 1, 0, 4'd0, 0, 64'd1, 64'd9);
    step(1, 3'd2, 0, 1, 0, 4'd0, 0, 64'd1, 64'd9);
    step(1, 3'd3, 1, 0, 0, 4'd0, 0, 64'd1, 64'd9);
    step(1, 3'd0, 0, 0, 0, 4'd0, 0, 64'd1, 64'd9);
    step(1, 3'd1, 0, 1, 0, 4'd0, 0, 64'd1, 64'd9);
    step(1, 3'd1, 1, 1, 0, 4'd0, 0, 64'd1, 64'd9);
    step(1, 3'd4, 0, 0, 0, 4'd0, 0, 64'd1, 64'd9);
    // unused mode codes
    step(1, 3'd5, 1, 0, 0, 4'd0, 0, 64'd1, 64'd9);
    step(1, 3'd7, 1, 0, 0, 4'd0, 0, 64'd20, 64'd9);
    // memory form
    step(1, 3'd4, 0, 0, 0, 4'd0, 1, 64'd8, 64'd9);
    step(1, 3'd4, 0, 0, 0, 4'd0, 1, 64'd9, 64'd9);
    step(1, 3'd2, 1, 0, 0, 4'd1, 1, 64'd8, 64'd9);
    // idle gaps
    step(0, 3'd4, 0, 0, 0, 4'd0, 0, 64'd1, 64'd9);
    step(0, 3'd4, 0, 0, 1, 4'd9, 0, 64'd1, 64'd9);
    step(1, 3'd4, 0, 0, 0, 4'd0, 0, 64'd1, 64'd9);

    // random traffic
    for (int i = 0; i < 1500; i++) begin
      logic [63:0] lb, op;
      lb = {$urandom(), $urandom()};
      if ($urandom() % 2 == 0) lb = lb >> ($urandom() % 64);
      case ($urandom() % 4)
        0: op = lb;
        1: op = lb - 64'd1;
        2: op = lb + 64'd1;
        default: op = {$urandom(), $urandom()};
      endcase
      step(($urandom() % 5) != 0, 3'($urandom() % 8), 1'($urandom()),
           1'($urandom()), ($urandom() % 8) == 0, 4'($urandom() % 6),
           1'($urandom()), op, lb);
    end
    step(0, 3'd4, 0, 0, 0, 4'd0, 0, 64'd0, 64'd0);
    @(negedge clk);
    compareOut();
    finishRun();
  end

endmodule